// File: doc/BRIEF.md
# Two-Level Next Fetch Block Predictor

This block predicts where the next fetch block starts. Each cycle the fetch side may present the start address of the current block together with a direction from an external branch predictor and the top of an external return-address stack. A small direct-mapped first level answers in one cycle. On a hit it returns the stored branch kind, an oversize flag and the next block address. That address is the stored target or the return address when the prediction is taken. It is the block start plus a short fall-through offset when the prediction is not taken.

On a first-level miss the block assumes fall-through at once, using a fixed default block length. It also launches a probe into a larger two-way set-associative second level, which answers a fixed number of cycles later. A second-level hit is sent out on a redirect port and copied into the first level. A miss in both levels produces nothing, and the fall-through guess stands. Resolved taken branches are written into both levels through an update port. Not-taken outcomes allocate nothing.

Top module: `next_block_predictor`

## Requirements
- R1: A lookup presented at one rising edge gives `pred_valid`=1 after that edge, and only then. Reset clears `pred_valid`, `redir_valid` and every valid bit in both levels.
- R2: On a first-level hit with `look_taken`=0, `pred_next` is `look_pc` + 4 × the stored 5-bit fall-through offset, and `pred_hit`=1.
- R3: On a first-level miss, `pred_hit`=0 and `pred_next` is `look_pc` + 4 × `MISS_INSTR` (32 bytes by default), whatever the direction input.
- R4: On a first-level hit with `look_taken`=1 and a stored kind other than return, `pred_next` is the stored target. `pred_kind` reports the stored kind, encoded as conditional=0, call=1, return=2.
- R5: On a first-level hit with `look_taken`=1 and stored kind return (2), `pred_next` is `look_ret_addr`.
- R6: An update with `upd_taken`=0 writes neither level, so a later lookup of that address misses.
- R7: The oversize flag stored for an entry is 1 exactly when 4 × the fall-through offset exceeds `LINE_BYTES` (32 by default).
- R8: A first-level miss probes the second level. On a second-level hit, `redir_valid` rises `L2_LAT` cycles after `pred_valid` (3 by default), carrying the probed block address and its stored target. A second-level miss raises no redirect.
- R9: A second-level hit refills the first level, so a later lookup of that address hits in one cycle.
- R10: The second level keeps 2 ways per set with least-recently-used replacement. A third taken block mapping to a full set evicts the least recently used one.
- R11: The first level is indexed by address bits [5:2] (16 entries). The second level is indexed by bits [6:2] (32 sets). Both compare the remaining upper bits as the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| look_valid | input | 1 | Lookup request this cycle |
| look_pc | input | 32 | Start address of the current block |
| look_taken | input | 1 | Direction from the external predictor |
| look_ret_addr | input | 32 | Top of the external return-address stack |
| upd_valid | input | 1 | Resolved branch update |
| upd_pc | input | 32 | Block start address of the resolved branch |
| upd_taken | input | 1 | Branch was taken (only taken outcomes allocate) |
| upd_target | input | 32 | Resolved target |
| upd_kind | input | 2 | Branch kind: 0 conditional, 1 call, 2 return |
| upd_ft | input | 5 | Fall-through offset in instructions |
| pred_valid | output | 1 | Prediction valid |
| pred_next | output | 32 | Predicted next block address |
| pred_hit | output | 1 | First level hit |
| pred_kind | output | 2 | Branch kind of the hit entry |
| pred_oversize | output | 1 | Hit block is larger than a cache line |
| redir_valid | output | 1 | Second-level hit after a first-level miss |
| redir_pc | output | 32 | Block address that was probed |
| redir_target | output | 32 | Stored target from the second level |
| redir_kind | output | 2 | Stored branch kind |
| redir_oversize | output | 1 | Stored oversize flag |
| redir_ft | output | 5 | Stored fall-through offset |

## Verification
The assertions assume that reset is held from time zero for at least one edge. They also assume that the update port never writes two ways of one second-level set with the same tag. That holds because an update always overwrites a matching way before it considers a victim. The stimulus keeps lookups one cycle wide and separates them by more than the second-level latency. Each redirect can therefore be tied to a single probe. Every address the bench uses is word aligned, and only 2-bit kind codes 0 to 2 are applied.

// File: rtl/nbp_pkg.sv
package nbp_pkg;
  typedef enum logic [1:0] {
    BR_COND = 2'd0,
    BR_CALL = 2'd1,
    BR_RET  = 2'd2
  } br_kind_e;

  localparam int KIND_W = 2;
endpackage

// File: rtl/nbp_l1.sv
module nbp_l1 #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  parameter int FT_W  = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] rd_pc,
  output logic            rd_hit,
  output logic [PC_W-1:0] rd_target,
  output logic [1:0]      rd_kind,
  output logic            rd_ovs,
  output logic [FT_W-1:0] rd_ft,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_pc,
  input  logic [PC_W-1:0] wr_target,
  input  logic [1:0]      wr_kind,
  input  logic            wr_ovs,
  input  logic [FT_W-1:0] wr_ft
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = PC_W - 2 - IDX_W;

  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [PC_W-1:0]  tgt_mem [DEPTH];
  logic [1:0]       kind_mem[DEPTH];
  logic             ovs_mem [DEPTH];
  logic [FT_W-1:0]  ft_mem  [DEPTH];
  logic [DEPTH-1:0] valid_q;

  logic [IDX_W-1:0] rd_idx, wr_idx;
  assign rd_idx = rd_pc[IDX_W+1:2];
  assign wr_idx = wr_pc[IDX_W+1:2];

  assign rd_hit    = valid_q[rd_idx] && (tag_mem[rd_idx] == rd_pc[PC_W-1:IDX_W+2]);
  assign rd_target = tgt_mem[rd_idx];
  assign rd_kind   = kind_mem[rd_idx];
  assign rd_ovs    = ovs_mem[rd_idx];
  assign rd_ft     = ft_mem[rd_idx];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_pc[PC_W-1:IDX_W+2];
      tgt_mem[wr_idx]  <= wr_target;
      kind_mem[wr_idx] <= wr_kind;
      ovs_mem[wr_idx]  <= wr_ovs;
      ft_mem[wr_idx]   <= wr_ft;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  // R6
  l1_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(valid_q));
endmodule

// File: rtl/nbp_l2.sv
module nbp_l2 #(
  parameter int PC_W  = 32,
  parameter int SET_W = 5,
  parameter int FT_W  = 5,
  parameter int LAT   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            probe_valid,
  input  logic [PC_W-1:0] probe_pc,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_pc,
  input  logic [PC_W-1:0] wr_target,
  input  logic [1:0]      wr_kind,
  input  logic            wr_ovs,
  input  logic [FT_W-1:0] wr_ft,
  output logic            hit_valid,
  output logic [PC_W-1:0] hit_pc,
  output logic [PC_W-1:0] hit_target,
  output logic [1:0]      hit_kind,
  output logic            hit_ovs,
  output logic [FT_W-1:0] hit_ft
);
  localparam int WAYS  = 2;
  localparam int SETS  = 1 << SET_W;
  localparam int TAG_W = PC_W - 2 - SET_W;

  logic [TAG_W-1:0] tag_mem [WAYS][SETS];
  logic [PC_W-1:0]  tgt_mem [WAYS][SETS];
  logic [1:0]       kind_mem[WAYS][SETS];
  logic             ovs_mem [WAYS][SETS];
  logic [FT_W-1:0]  ft_mem  [WAYS][SETS];
  logic [SETS-1:0]  valid_q [WAYS];
  logic [SETS-1:0]  lru_q;   // way to replace next

  // fixed-latency probe delay line
  logic            dly_v [LAT];
  logic [PC_W-1:0] dly_pc[LAT];
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LAT; i++) dly_v[i] <= 1'b0;
    end else begin
      dly_v[0] <= probe_valid;
      for (int i = 1; i < LAT; i++) dly_v[i] <= dly_v[i-1];
    end
    dly_pc[0] <= probe_pc;
    for (int i = 1; i < LAT; i++) dly_pc[i] <= dly_pc[i-1];
  end

  logic            pv;
  logic [PC_W-1:0] ppc;
  logic [SET_W-1:0] pset, wset;
  assign pv   = dly_v[LAT-1];
  assign ppc  = dly_pc[LAT-1];
  assign pset = ppc[SET_W+1:2];
  assign wset = wr_pc[SET_W+1:2];

  logic [WAYS-1:0] p_hit, w_hit;
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign p_hit[w] = valid_q[w][pset] && (tag_mem[w][pset] == ppc[PC_W-1:SET_W+2]);
    assign w_hit[w] = valid_q[w][wset] && (tag_mem[w][wset] == wr_pc[PC_W-1:SET_W+2]);
  end

  logic p_way, w_way;
  assign p_way = p_hit[1];
  always_comb begin
    if (w_hit[0])             w_way = 1'b0;
    else if (w_hit[1])        w_way = 1'b1;
    else if (!valid_q[0][wset]) w_way = 1'b0;
    else if (!valid_q[1][wset]) w_way = 1'b1;
    else                      w_way = lru_q[wset];
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[w_way][wset]  <= wr_pc[PC_W-1:SET_W+2];
      tgt_mem[w_way][wset]  <= wr_target;
      kind_mem[w_way][wset] <= wr_kind;
      ovs_mem[w_way][wset]  <= wr_ovs;
      ft_mem[w_way][wset]   <= wr_ft;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < WAYS; w++) valid_q[w] <= '0;
      lru_q <= '0;
    end else begin
      if (pv && (|p_hit) && !(wr_en && wset == pset)) lru_q[pset] <= ~p_way;
      if (wr_en) begin
        valid_q[w_way][wset] <= 1'b1;
        lru_q[wset]          <= ~w_way;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hit_valid <= 1'b0;
    else     hit_valid <= pv && (|p_hit);
    hit_pc     <= ppc;
    hit_target <= tgt_mem[p_way][pset];
    hit_kind   <= kind_mem[p_way][pset];
    hit_ovs    <= ovs_mem[p_way][pset];
    hit_ft     <= ft_mem[p_way][pset];
  end

  // R10
  l2_unique_way_chk: assert property (@(posedge clk) disable iff (rst)
    pv |-> $onehot0(p_hit));
  // R8
  l2_hit_from_probe_chk: assert property (@(posedge clk) disable iff (rst)
    hit_valid |-> $past(pv));
endmodule

// File: rtl/next_block_predictor.sv
module next_block_predictor #(
  parameter int PC_W       = 32,
  parameter int L1_IDX_W   = 4,
  parameter int L2_SET_W   = 5,
  parameter int FT_W       = 5,
  parameter int L2_LAT     = 3,
  parameter int MISS_INSTR = 8,
  parameter int LINE_BYTES = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            look_valid,
  input  logic [PC_W-1:0] look_pc,
  input  logic            look_taken,
  input  logic [PC_W-1:0] look_ret_addr,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target,
  input  logic [1:0]      upd_kind,
  input  logic [FT_W-1:0] upd_ft,
  output logic            pred_valid,
  output logic [PC_W-1:0] pred_next,
  output logic            pred_hit,
  output logic [1:0]      pred_kind,
  output logic            pred_oversize,
  output logic            redir_valid,
  output logic [PC_W-1:0] redir_pc,
  output logic [PC_W-1:0] redir_target,
  output logic [1:0]      redir_kind,
  output logic            redir_oversize,
  output logic [FT_W-1:0] redir_ft
);
  import nbp_pkg::*;

  localparam logic [PC_W-1:0] MISS_BYTES = PC_W'(MISS_INSTR * 4);
  localparam logic [FT_W+2:0] LINE_LIM   = (FT_W+3)'(LINE_BYTES);

  logic            upd_we, upd_ovs;
  assign upd_we  = upd_valid && upd_taken;   // never-taken blocks do not allocate
  assign upd_ovs = {1'b0, upd_ft, 2'b00} > LINE_LIM;

  // first level read
  logic            l1_hit, l1_ovs;
  logic [PC_W-1:0] l1_tgt;
  logic [1:0]      l1_kind;
  logic [FT_W-1:0] l1_ft;

  // first level write: update wins over refill
  logic            l1_we;
  logic [PC_W-1:0] l1_wpc, l1_wtgt;
  logic [1:0]      l1_wkind;
  logic            l1_wovs;
  logic [FT_W-1:0] l1_wft;
  always_comb begin
    l1_we = upd_we || redir_valid;
    if (upd_we) begin
      l1_wpc = upd_pc; l1_wtgt = upd_target; l1_wkind = upd_kind;
      l1_wovs = upd_ovs; l1_wft = upd_ft;
    end else begin
      l1_wpc = redir_pc; l1_wtgt = redir_target; l1_wkind = redir_kind;
      l1_wovs = redir_oversize; l1_wft = redir_ft;
    end
  end

  nbp_l1 #(.PC_W(PC_W), .IDX_W(L1_IDX_W), .FT_W(FT_W)) l1_i (
    .clk(clk), .rst(rst),
    .rd_pc(look_pc), .rd_hit(l1_hit), .rd_target(l1_tgt), .rd_kind(l1_kind),
    .rd_ovs(l1_ovs), .rd_ft(l1_ft),
    .wr_en(l1_we), .wr_pc(l1_wpc), .wr_target(l1_wtgt), .wr_kind(l1_wkind),
    .wr_ovs(l1_wovs), .wr_ft(l1_wft)
  );

  nbp_l2 #(.PC_W(PC_W), .SET_W(L2_SET_W), .FT_W(FT_W), .LAT(L2_LAT)) l2_i (
    .clk(clk), .rst(rst),
    .probe_valid(look_valid && !l1_hit), .probe_pc(look_pc),
    .wr_en(upd_we), .wr_pc(upd_pc), .wr_target(upd_target), .wr_kind(upd_kind),
    .wr_ovs(upd_ovs), .wr_ft(upd_ft),
    .hit_valid(redir_valid), .hit_pc(redir_pc), .hit_target(redir_target),
    .hit_kind(redir_kind), .hit_ovs(redir_oversize), .hit_ft(redir_ft)
  );

  // next block selection
  logic [PC_W-1:0] nxt;
  always_comb begin
    if (!l1_hit)                    nxt = look_pc + MISS_BYTES;
    else if (!look_taken)           nxt = look_pc + PC_W'({l1_ft, 2'b00});
    else if (l1_kind == 2'(BR_RET)) nxt = look_ret_addr;
    else                            nxt = l1_tgt;
  end

  always_ff @(posedge clk) begin
    if (rst) pred_valid <= 1'b0;
    else     pred_valid <= look_valid;
    pred_next     <= nxt;
    pred_hit      <= l1_hit;
    pred_kind     <= l1_hit ? l1_kind : 2'(BR_COND);
    pred_oversize <= l1_hit && l1_ovs;
  end

  // R1
  pred_follows_look_chk: assert property (@(posedge clk) disable iff (rst)
    pred_valid |-> $past(look_valid));
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    $past(rst) |-> (!pred_valid && !redir_valid));
  // R3
  miss_fallthrough_chk: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && !pred_hit) |-> (pred_next == $past(look_pc) + MISS_BYTES));
  // R5
  ret_uses_stack_chk: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && pred_hit && pred_kind == 2'(BR_RET) && $past(look_taken))
      |-> (pred_next == $past(look_ret_addr)));
endmodule

// File: tb/next_block_predictor_tb_top.sv
module next_block_predictor_tb_top;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;   // 250 MHz

  logic        look_valid = 0, look_taken = 0, upd_valid = 0, upd_taken = 0;
  logic [31:0] look_pc = 0, look_ret_addr = 0, upd_pc = 0, upd_target = 0;
  logic [1:0]  upd_kind = 0;
  logic [4:0]  upd_ft = 0;
  logic        pred_valid, pred_hit, pred_oversize, redir_valid, redir_oversize;
  logic [31:0] pred_next, redir_pc, redir_target;
  logic [1:0]  pred_kind, redir_kind;
  logic [4:0]  redir_ft;

  next_block_predictor dut_i (
    .clk(clk), .rst(rst), .look_valid(look_valid), .look_pc(look_pc),
    .look_taken(look_taken), .look_ret_addr(look_ret_addr),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target), .upd_kind(upd_kind), .upd_ft(upd_ft),
    .pred_valid(pred_valid), .pred_next(pred_next), .pred_hit(pred_hit),
    .pred_kind(pred_kind), .pred_oversize(pred_oversize),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .redir_target(redir_target),
    .redir_kind(redir_kind), .redir_oversize(redir_oversize), .redir_ft(redir_ft)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic update(input logic [31:0] pc, input logic tk, input logic [31:0] tgt,
                        input logic [1:0] kind, input logic [4:0] ft);
    @(negedge clk);
    upd_valid = 1; upd_pc = pc; upd_taken = tk; upd_target = tgt; upd_kind = kind; upd_ft = ft;
    @(negedge clk);
    upd_valid = 0; upd_taken = 0;
  endtask

  // one-cycle lookup; result sampled at the next falling edge
  task automatic lookup(input logic [31:0] pc, input logic tk, input logic [31:0] ra);
    @(negedge clk);
    look_valid = 1; look_pc = pc; look_taken = tk; look_ret_addr = ra;
    @(negedge clk);
    look_valid = 0;
  endtask

  // returns the cycle count after pred at which redirect appeared, 0 if none
  task automatic wait_redir(output int at, output logic [31:0] tgt, output logic [31:0] pc);
    at = 0; tgt = 0; pc = 0;
    for (int k = 1; k <= LAT + 3; k++) begin
      @(negedge clk);
      if (redir_valid && at == 0) begin at = k; tgt = redir_target; pc = redir_pc; end
    end
  endtask

  task automatic t_reset();
    chk("R1 pred_valid after reset", {31'b0, pred_valid}, 32'd0);
    chk("R1 redir_valid after reset", {31'b0, redir_valid}, 32'd0);
  endtask

  task automatic t_cold_miss();
    int at; logic [31:0] t, p;
    lookup(32'h0000_0104, 1'b1, 32'h0);
    chk("R1 pred_valid on lookup", {31'b0, pred_valid}, 32'd1);
    chk("R3 miss hit flag", {31'b0, pred_hit}, 32'd0);
    chk("R3 miss default next", pred_next, 32'h0000_0124);
    wait_redir(at, t, p);
    chk("R8 no redirect on double miss", at, 0);
  endtask

  task automatic t_cond();
    update(32'h0000_0104, 1'b1, 32'h0000_5000, 2'd0, 5'd5);
    lookup(32'h0000_0104, 1'b0, 32'h0);
    chk("R2 hit flag", {31'b0, pred_hit}, 32'd1);
    chk("R2 not-taken fall-through", pred_next, 32'h0000_0118);
    lookup(32'h0000_0104, 1'b1, 32'h0);
    chk("R4 taken target", pred_next, 32'h0000_5000);
    chk("R4 kind conditional", {30'b0, pred_kind}, 32'd0);
    update(32'h0000_0120, 1'b1, 32'h0000_6000, 2'd1, 5'd3);
    lookup(32'h0000_0120, 1'b1, 32'h0000_7777);
    chk("R4 call target", pred_next, 32'h0000_6000);
    chk("R4 kind call", {30'b0, pred_kind}, 32'd1);
  endtask

  task automatic t_not_taken_no_alloc();
    update(32'h0000_0108, 1'b0, 32'h0000_9000, 2'd0, 5'd4);
    lookup(32'h0000_0108, 1'b1, 32'h0);
    chk("R6 not-taken update leaves miss", {31'b0, pred_hit}, 32'd0);
    chk("R6 next is miss default", pred_next, 32'h0000_0128);
  endtask

  task automatic t_return();
    update(32'h0000_010C, 1'b1, 32'h0000_AAAA, 2'd2, 5'd2);
    lookup(32'h0000_010C, 1'b1, 32'h0000_3330);
    chk("R5 return uses stack address", pred_next, 32'h0000_3330);
    chk("R5 kind return", {30'b0, pred_kind}, 32'd2);
    lookup(32'h0000_010C, 1'b0, 32'h0000_3330);
    chk("R2 return not taken falls through", pred_next, 32'h0000_0114);
  endtask

  task automatic t_oversize();
    update(32'h0000_0110, 1'b1, 32'h0000_1000, 2'd0, 5'd9);
    lookup(32'h0000_0110, 1'b0, 32'h0);
    chk("R7 36 bytes is oversize", {31'b0, pred_oversize}, 32'd1);
    update(32'h0000_0114, 1'b1, 32'h0000_1000, 2'd0, 5'd8);
    lookup(32'h0000_0114, 1'b0, 32'h0);
    chk("R7 32 bytes is not oversize", {31'b0, pred_oversize}, 32'd0);
  endtask

  task automatic t_refill();
    int at; logic [31:0] t, p;
    update(32'h0000_1018, 1'b1, 32'h0000_D000, 2'd0, 5'd6);
    update(32'h0000_1058, 1'b1, 32'h0000_E000, 2'd0, 5'd6);   // same first-level index (R11)
    lookup(32'h0000_1018, 1'b1, 32'h0);
    chk("R11 aliased entry evicted from first level", {31'b0, pred_hit}, 32'd0);
    chk("R3 fall-through while probing", pred_next, 32'h0000_1038);
    wait_redir(at, t, p);
    chk("R8 redirect latency", at, LAT);
    chk("R8 redirect target", t, 32'h0000_D000);
    chk("R8 redirect pc", p, 32'h0000_1018);
    lookup(32'h0000_1018, 1'b1, 32'h0);
    chk("R9 refilled entry hits", {31'b0, pred_hit}, 32'd1);
    chk("R9 refilled target", pred_next, 32'h0000_D000);
  endtask

  task automatic t_lru();
    int at; logic [31:0] t, p;
    update(32'h0000_2040, 1'b1, 32'h0000_0A00, 2'd0, 5'd1);
    update(32'h0000_20C0, 1'b1, 32'h0000_0B00, 2'd0, 5'd1);
    update(32'h0000_2140, 1'b1, 32'h0000_0C00, 2'd0, 5'd1);
    lookup(32'h0000_2040, 1'b1, 32'h0);
    wait_redir(at, t, p);
    chk("R10 oldest way evicted", at, 0);
    lookup(32'h0000_20C0, 1'b1, 32'h0);
    wait_redir(at, t, p);
    chk("R10 newer way kept", t, 32'h0000_0B00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_cold_miss();
    t_cond();
    t_not_taken_no_alloc();
    t_return();
    t_oversize();
    t_refill();
    t_lru();
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule